// File: doc/BRIEF.md
# Programmable RGB Color Matrix

This block applies a programmable 3×3 matrix to a stream of RGB pixels with 12-bit components. Every output component is the weighted sum of the three input components, with weights in signed fixed point (3 integer bits, 12 fractional bits, 15 bits in two's complement). The result is scaled back to 12 bits and saturated. Pixels move through a two-stage valid/ready pipeline that carries a start-of-frame marker alongside each pixel.

Software supplies the nine weights as 64-bit words in sign-magnitude format with 32 fractional bits. Each word is converted and range-checked as it arrives. A complete set of nine is kept only if every word converts cleanly. An accepted set waits in a shadow bank and replaces the working matrix all at once when the next start-of-frame pixel enters. A set that contains any bad word raises an error flag and is dropped.

Top module: `color_matrix_top`

## Requirements
- R1: After reset the working matrix is the identity (1.0 on the diagonal, 0 elsewhere), load_err is 0, out_valid is 0 and in_ready is 1.
- R2: A load word converts by taking bits 34:20 as a 15-bit magnitude. Bits 19:0 are dropped without rounding, and bits 62:35 are discarded.
- R3: When bit 63 of a load word is set, the 15-bit magnitude is negated in two's complement. A word with sign set and magnitude field 0x4000 is accepted as -4.0.
- R4: A word is bad when its bit 63 differs from bit 14 of the converted value. This covers positive words with magnitude field 0x4000 or more, and words with the sign set and a zero magnitude field.
- R5: When a completed set of nine holds any bad word, load_err goes to 1 and the working matrix is unchanged. A later set with no bad word clears load_err. load_err changes only in a cycle in which a load word is taken.
- R6: Word k of a set (k = 0..8) is the weight in row k/3, column k%3. Row 0 forms out_r, row 1 forms out_g and row 2 forms out_b. Column 0 multiplies R, column 1 multiplies G and column 2 multiplies B. Asserting load_first with a word restarts the set at k = 0 and discards any partial set together with its bad-word history.
- R7: A fully accepted set becomes the working matrix when a pixel with in_sof = 1 is taken. That pixel and all later pixels use the new set, and pixels taken before it use the old set.
- R8: Each output component is the sum of its row's three products, shifted right arithmetically by 12 and clamped to 0..4095.
- R9: A pixel taken at one rising edge appears on the output after the second rising edge. While out_valid is 1 and out_ready is 0 the output holds steady, and in_ready drops once both stages are occupied.
- R10: out_sof carries the in_sof value of the pixel currently shown on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| load_valid | input | 1 | A load word is presented this cycle |
| load_first | input | 1 | This load word is word 0 of a new set |
| load_word | input | 64 | Sign-magnitude weight, 32 fractional bits |
| load_err | output | 1 | Last completed set was rejected |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_r | input | 12 | Input red component |
| in_g | input | 12 | Input green component |
| in_b | input | 12 | Input blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_r | output | 12 | Output red component |
| out_g | output | 12 | Output green component |
| out_b | output | 12 | Output blue component |

## Verification
A load word presented at one rising edge affects load_err by the next falling edge. The bench drives each word half a cycle early and samples the flag one half cycle after the edge. With out_ready high, a pixel taken at a rising edge is on the outputs after the following rising edge. Each pixel task therefore drives at a falling edge, withdraws the pixel after one edge and compares the results at the falling edge after the second. In the back-pressure scenario the bench holds out_ready low for several cycles, checks that the output stays steady and that in_ready is low, and then expects the queued pixel one cycle after it raises out_ready.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int unsigned CMX_COMP_W  = 12;
  localparam int unsigned CMX_FRAC_W  = 12;
  localparam int unsigned CMX_INT_W   = 3;
  localparam int unsigned CMX_LOAD_W  = 64;
  localparam int unsigned CMX_LOAD_FR = 32;
  localparam int unsigned CMX_DIM     = 3;
endpackage

// File: rtl/cmx_rst_sync.sv
module cmx_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cmx_coef_conv.sv
module cmx_coef_conv #(
  parameter int unsigned IN_W    = cmx_pkg::CMX_LOAD_W,
  parameter int unsigned IN_FRAC = cmx_pkg::CMX_LOAD_FR,
  parameter int unsigned COEF_W  = cmx_pkg::CMX_INT_W + cmx_pkg::CMX_FRAC_W,
  parameter int unsigned FRAC_W  = cmx_pkg::CMX_FRAC_W
) (
  input  logic [IN_W-1:0]   raw,
  output logic [COEF_W-1:0] q,
  output logic              bad
);
  localparam int unsigned SHIFT = IN_FRAC - FRAC_W;

  logic              neg;
  logic [COEF_W-1:0] mag;

  always_comb begin
    neg = raw[IN_W-1];
    mag = raw[SHIFT+COEF_W-1:SHIFT];
    q   = neg ? (~mag + 1'b1) : mag;
    // range test after negation: sign must survive into the top bit
    bad = (neg != q[COEF_W-1]);
  end
endmodule

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank #(
  parameter int unsigned DIM     = cmx_pkg::CMX_DIM,
  parameter int unsigned COEF_W  = cmx_pkg::CMX_INT_W + cmx_pkg::CMX_FRAC_W,
  parameter int unsigned FRAC_W  = cmx_pkg::CMX_FRAC_W,
  parameter int unsigned IN_W    = cmx_pkg::CMX_LOAD_W,
  parameter int unsigned IN_FRAC = cmx_pkg::CMX_LOAD_FR,
  localparam int unsigned NC     = DIM * DIM
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_valid,
  input  logic                        ld_first,
  input  logic [IN_W-1:0]             ld_data,
  input  logic                        commit,
  output logic [NC-1:0][COEF_W-1:0]   eff_coef,
  output logic [NC-1:0][COEF_W-1:0]   act_coef,
  output logic [NC-1:0][COEF_W-1:0]   shd_coef,
  output logic                        cfg_err
);
  localparam int unsigned IW = (NC > 1) ? $clog2(NC) : 1;
  localparam logic [IW-1:0] LAST = IW'(NC - 1);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

  function automatic logic [NC-1:0][COEF_W-1:0] unit_set();
    for (int k = 0; k < NC; k++)
      unit_set[k] = ((k / DIM) == (k % DIM)) ? UNITY : '0;
  endfunction

  logic [COEF_W-1:0]             conv_q;
  logic                          conv_bad;
  logic [IW-1:0]                 cnt_q, cnt_n, idx;
  logic                          bad_q, bad_n, acc_bad;
  logic                          set_done, take;
  logic                          pend_q, pend_n, err_q, err_n;
  logic [NC-1:0][COEF_W-1:0]     stg_q, stg_n, shd_q, shd_n, act_q, act_n;

  cmx_coef_conv #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
  ) u_conv (
    .raw (ld_data),
    .q   (conv_q),
    .bad (conv_bad)
  );

  always_comb begin
    idx      = ld_first ? '0 : cnt_q;
    stg_n    = stg_q;
    stg_n[idx] = conv_q;
    acc_bad  = conv_bad | (~ld_first & bad_q);
    set_done = ld_valid & (idx == LAST);
    cnt_n    = (idx == LAST) ? '0 : idx + 1'b1;
    bad_n    = set_done ? 1'b0 : acc_bad;

    take     = commit & pend_q;
    act_n    = take ? shd_q : act_q;
    pend_n   = pend_q & ~take;
    shd_n    = shd_q;
    err_n    = err_q;
    if (set_done) begin
      if (!acc_bad) begin
        shd_n  = stg_n;
        pend_n = 1'b1;
        err_n  = 1'b0;
      end else begin
        err_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bad_q  <= 1'b0;
      stg_q  <= unit_set();
      shd_q  <= unit_set();
      act_q  <= unit_set();
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ld_valid) begin
        cnt_q <= cnt_n;
        bad_q <= bad_n;
        stg_q <= stg_n;
      end
      if (set_done) begin
        shd_q <= shd_n;
        err_q <= err_n;
      end
      pend_q <= pend_n;
      if (take) act_q <= act_n;
    end
  end

  assign eff_coef = take ? shd_q : act_q;
  assign act_coef = act_q;
  assign shd_coef = shd_q;
  assign cfg_err  = err_q;
endmodule

// File: rtl/cmx_pixel_pipe.sv
module cmx_pixel_pipe #(
  parameter int unsigned DIM    = cmx_pkg::CMX_DIM,
  parameter int unsigned COMP_W = cmx_pkg::CMX_COMP_W,
  parameter int unsigned COEF_W = cmx_pkg::CMX_INT_W + cmx_pkg::CMX_FRAC_W,
  parameter int unsigned FRAC_W = cmx_pkg::CMX_FRAC_W,
  localparam int unsigned NC    = DIM * DIM
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sof,
  input  logic [DIM-1:0][COMP_W-1:0]  in_pix,
  input  logic [NC-1:0][COEF_W-1:0]   coef,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_sof,
  output logic [DIM-1:0][COMP_W-1:0]  out_pix,
  output logic                        mid_valid
);
  localparam int unsigned PW = COEF_W + COMP_W + 1;
  localparam int unsigned SW = PW + $clog2(DIM) + 1;
  localparam int unsigned MAXV = (1 << COMP_W) - 1;
  localparam logic signed [SW-1:0] MAXS = SW'(MAXV);

  logic signed [PW-1:0] prd_n [NC];
  logic signed [PW-1:0] prd_q [NC];
  logic [COMP_W-1:0]    row_n [DIM];
  logic [COMP_W-1:0]    row_q [DIM];
  logic                 v1_q, v1_n, v2_q, v2_n, sof1_q, sof2_q;
  logic                 adv2, rdy, ld1, ld2;

  always_comb begin
    adv2 = ~v2_q | out_ready;
    rdy  = ~v1_q | adv2;
    ld1  = in_valid & rdy;
    ld2  = v1_q & adv2;
    v1_n = rdy  ? in_valid : v1_q;
    v2_n = adv2 ? v1_q     : v2_q;
  end

  for (genvar k = 0; k < NC; k++) begin : g_mul
    assign prd_n[k] = $signed(coef[k]) * $signed({1'b0, in_pix[k % DIM]});
  end

  for (genvar i = 0; i < DIM; i++) begin : g_row
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] sh;
    always_comb begin
      acc = '0;
      for (int j = 0; j < DIM; j++)
        acc = acc + SW'(prd_q[i*DIM + j]);
      sh = acc >>> FRAC_W;
      if (sh < 0)         row_n[i] = '0;
      else if (sh > MAXS) row_n[i] = COMP_W'(MAXV);
      else                row_n[i] = sh[COMP_W-1:0];
    end
    assign out_pix[i] = row_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_n;
      v2_q <= v2_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ld1) begin
      sof1_q <= in_sof;
      for (int k = 0; k < NC; k++) prd_q[k] <= prd_n[k];
    end
    if (ld2) begin
      sof2_q <= sof1_q;
      for (int i = 0; i < DIM; i++) row_q[i] <= row_n[i];
    end
  end

  assign in_ready  = rdy;
  assign out_valid = v2_q;
  assign out_sof   = sof2_q;
  assign mid_valid = v1_q;
endmodule

// File: rtl/color_matrix_top.sv
module color_matrix_top #(
  parameter int unsigned COMP_W  = cmx_pkg::CMX_COMP_W,
  parameter int unsigned FRAC_W  = cmx_pkg::CMX_FRAC_W,
  parameter int unsigned INT_W   = cmx_pkg::CMX_INT_W,
  parameter int unsigned LOAD_W  = cmx_pkg::CMX_LOAD_W,
  parameter int unsigned LOAD_FR = cmx_pkg::CMX_LOAD_FR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic              load_first,
  input  logic [LOAD_W-1:0] load_word,
  output logic              load_err,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [COMP_W-1:0] in_r,
  input  logic [COMP_W-1:0] in_g,
  input  logic [COMP_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sof,
  output logic [COMP_W-1:0] out_r,
  output logic [COMP_W-1:0] out_g,
  output logic [COMP_W-1:0] out_b
);
  localparam int unsigned DIM    = 3;
  localparam int unsigned NC     = DIM * DIM;
  localparam int unsigned COEF_W = INT_W + FRAC_W;

  logic                        rst_s;
  logic                        commit;
  logic                        mid_valid;
  logic [NC-1:0][COEF_W-1:0]   eff_coef, act_coef, shd_coef;
  logic [DIM-1:0][COMP_W-1:0]  pix_in, pix_out;

  cmx_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  assign commit = in_valid & in_ready & in_sof;
  assign pix_in = {in_b, in_g, in_r};

  cmx_coef_bank #(
    .DIM(DIM), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .IN_W(LOAD_W), .IN_FRAC(LOAD_FR)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_s),
    .ld_valid (load_valid),
    .ld_first (load_first),
    .ld_data  (load_word),
    .commit   (commit),
    .eff_coef (eff_coef),
    .act_coef (act_coef),
    .shd_coef (shd_coef),
    .cfg_err  (load_err)
  );

  cmx_pixel_pipe #(
    .DIM(DIM), .COMP_W(COMP_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .in_pix    (pix_in),
    .coef      (eff_coef),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sof   (out_sof),
    .out_pix   (pix_out),
    .mid_valid (mid_valid)
  );

  assign out_r = pix_out[0];
  assign out_g = pix_out[1];
  assign out_b = pix_out[2];
endmodule

// File: rtl/cmx_checker.sv
module cmx_checker #(
  parameter int unsigned COMP_W = 12,
  parameter int unsigned SET_W  = 135
) (
  input logic              clk,
  input logic              rst_s,
  input logic              load_valid,
  input logic              load_err,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sof,
  input logic [COMP_W-1:0] out_r,
  input logic [COMP_W-1:0] out_g,
  input logic [COMP_W-1:0] out_b,
  input logic              mid_valid,
  input logic [SET_W-1:0]  act_coef,
  input logic [SET_W-1:0]  shd_coef
);
  // R7: the working matrix moves only when a start-of-frame pixel is taken
  a_r7_swap_at_sof: assert property (@(posedge clk) disable iff (!rst_s)
    !(in_valid && in_ready && in_sof) |=> $stable(act_coef));

  // R5: a rejected set leaves the shadow bank untouched
  a_r5_reject_keeps_shadow: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(load_err) |-> $stable(shd_coef));

  // R5: the error flag moves only on a load word
  a_r5_err_on_load: assert property (@(posedge clk) disable iff (!rst_s)
    !load_valid |=> $stable(load_err));

  // R9: stalled output holds
  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g)
                                   && $stable(out_b) && $stable(out_sof)));

  // R9: no room when both stages are full and the output is stalled
  a_r9_full_not_ready: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready && mid_valid) |-> !in_ready);
endmodule

bind color_matrix_top cmx_checker #(
  .COMP_W (COMP_W),
  .SET_W  (NC * COEF_W)
) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .load_valid (load_valid),
  .load_err   (load_err),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sof     (in_sof),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sof    (out_sof),
  .out_r      (out_r),
  .out_g      (out_g),
  .out_b      (out_b),
  .mid_valid  (mid_valid),
  .act_coef   (act_coef),
  .shd_coef   (shd_coef)
);

// File: tb/color_matrix_top_test.sv
module color_matrix_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_valid, load_first;
  logic [63:0] load_word;
  logic        load_err;
  logic        in_valid, in_ready, in_sof;
  logic [11:0] in_r, in_g, in_b;
  logic        out_valid, out_ready, out_sof;
  logic [11:0] out_r, out_g, out_b;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [63:0] lw [9];

  always #5 clk = ~clk;

  color_matrix_top uut (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_first(load_first), .load_word(load_word),
    .load_err(load_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic logic [63:0] mk(input bit neg, input int mag);
    return ({neg, 63'd0}) | (64'(mag) << 20);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [63:0] d, input bit first);
    @(negedge clk);
    load_valid = 1'b1; load_first = first; load_word = d;
    @(negedge clk);
    load_valid = 1'b0; load_first = 1'b0;
  endtask

  task automatic load_set();
    for (int k = 0; k < 9; k++) send_word(lw[k], k == 0);
  endtask

  task automatic pix(input int r, input int g, input int b, input bit sof,
                     input int er, input int eg, input int eb, input string req);
    @(negedge clk);
    chk(in_ready == 1'b1, req, int'(in_ready), 1);
    in_valid = 1'b1; in_sof = sof; in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, req, int'(out_valid), 1);
    chk(int'(out_r) == er, {req, " red"}, int'(out_r), er);
    chk(int'(out_g) == eg, {req, " green"}, int'(out_g), eg);
    chk(int'(out_b) == eb, {req, " blue"}, int'(out_b), eb);
    chk(out_sof == sof, {req, " R10 sof"}, int'(out_sof), int'(sof));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_valid = 1'b0; load_first = 1'b0; load_word = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_r = '0; in_g = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(load_err == 1'b0, "R1 load_err", int'(load_err), 0);
    pix(1234, 567, 4095, 1'b0, 1234, 567, 4095, "R1 identity");
  endtask

  // set A: R'=G, G'=B/2, B'=R-G; words 0 and 4 carry dropped bits (R2)
  task automatic t_load_commit();
    lw[0] = mk(0, 0) | 64'h0000_0000_000F_FFFF;
    lw[1] = mk(0, 4096);
    lw[2] = mk(0, 0);
    lw[3] = mk(0, 0);
    lw[4] = mk(0, 0) | (64'h1 << 40);
    lw[5] = mk(0, 2048) | 64'h0000_0000_0008_0000;
    lw[6] = mk(0, 4096);
    lw[7] = mk(1, 4096);
    lw[8] = mk(0, 0);
    load_set();
    chk(load_err == 1'b0, "R2 clean set", int'(load_err), 0);
    pix(1000, 3000, 500, 1'b0, 1000, 3000, 500, "R7 before sof");
    pix(1000, 3000, 500, 1'b1, 3000, 250, 0, "R7 R6 R8 at sof");
    pix(2000, 100, 801, 1'b0, 100, 400, 1900, "R7 after sof");
  endtask

  // set B: -4.0 corner, saturation high and low
  task automatic t_corner_clamp();
    lw[0] = mk(1, 16384); lw[1] = mk(0, 16383); lw[2] = mk(0, 0);
    lw[3] = mk(0, 16383); lw[4] = mk(0, 16383); lw[5] = mk(0, 16383);
    lw[6] = mk(1, 8192);  lw[7] = mk(0, 4096);  lw[8] = mk(0, 0);
    load_set();
    chk(load_err == 1'b0, "R3 minus four accepted", int'(load_err), 0);
    pix(100, 300, 50, 1'b1, 799, 1799, 100, "R3 R8 negative weights");
    pix(4095, 4095, 4095, 1'b0, 0, 4095, 0, "R8 clamp");
  endtask

  task automatic t_reject();
    for (int k = 0; k < 9; k++) lw[k] = mk(0, 4096);
    lw[5] = mk(0, 16384);
    load_set();
    chk(load_err == 1'b1, "R4 R5 positive four rejected", int'(load_err), 1);
    pix(100, 300, 50, 1'b1, 799, 1799, 100, "R5 set kept");
    for (int k = 0; k < 9; k++) lw[k] = mk(0, 1024);
    lw[2] = {1'b1, 63'd0};
    load_set();
    chk(load_err == 1'b1, "R4 negative zero rejected", int'(load_err), 1);
    pix(100, 300, 50, 1'b1, 799, 1799, 100, "R4 set kept");
  endtask

  // partial set holding a bad word, then restart with load_first
  task automatic t_restart();
    send_word(mk(0, 16384), 1'b1);
    send_word(mk(0, 100), 1'b0);
    send_word(mk(0, 200), 1'b0);
    chk(load_err == 1'b1, "R5 flag kept mid set", int'(load_err), 1);
    for (int k = 0; k < 9; k++) lw[k] = mk(0, 0);
    lw[0] = mk(0, 2048); lw[4] = mk(0, 2048); lw[8] = mk(0, 2048);
    load_set();
    chk(load_err == 1'b0, "R5 R6 clean set clears flag", int'(load_err), 0);
    pix(2000, 1000, 400, 1'b1, 1000, 500, 200, "R6 restart");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sof = 1'b0; in_r = 12'd2000; in_g = 12'd1000; in_b = 12'd400;
    @(negedge clk);
    in_r = 12'd4094; in_g = 12'd2; in_b = 12'd8;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 latency", int'(out_valid), 1);
    chk(out_r == 12'd1000, "R9 first red", int'(out_r), 1000);
    chk(in_ready == 1'b0, "R9 full", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk(out_r == 12'd1000 && out_g == 12'd500 && out_b == 12'd200, "R9 hold",
        int'(out_r), 1000);
    chk(in_ready == 1'b0, "R9 still full", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_r == 12'd2047, "R9 second red", int'(out_r), 2047);
    chk(out_g == 12'd1 && out_b == 12'd4, "R9 second green", int'(out_g), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_load_commit();
    t_corner_clamp();
    t_reject();
    t_restart();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule